// File: doc/BRIEF.md
# Capability record list walker

The block scans a chain of capability records held in a word-addressed configuration space and pulls out the parameters they carry. A pulse on `start_i` starts a scan at a fixed anchor offset. The walker issues 32-bit reads through a simple synchronous read port, decodes each record header and jumps from record to record until one of two things happens. Either it finds a terminator and raises `done_o`, or the chain is malformed and it raises `done_o` together with `err_o` and a reason code.

During the scan it latches the engine clock frequency and the mailbox window. It also flags whether the mailbox is large enough to be usable. Each record header holds three fields: a required flag, a type and a byte length. The length does not count the header word itself. A record type that the walker does not recognise is skipped, unless its required flag is set. Values that no record overrides keep their defaults.

Top module: `cap_list_walker`

## Requirements
- R1: After reset the walker is idle with `done_o`, `err_o` and `rd_en_o` low, `err_code_o` 0, `freq_mhz_o` 0, `mbox_off_o` 0x1800, `mbox_len_o` 0x1F8 and `mbox_ok_o` 1.
- R2: An accepted start reads the word at byte offset 0x58 (word address 0x16) first. If that word is zero the walk ends with `done_o` high, `err_o` low and all values at their defaults.
- R3: A header word carries the required flag in bit 31, the type in bits 30:16 and the byte length in bits 15:0. The next header is read at current offset + 4 + length.
- R4: A length whose two low bits are not both zero ends the walk with error code 2 (format).
- R5: Type 2 ends the walk without error. No record after it is read.
- R6: Type 0 ends the walk with error code 1, whatever its required flag.
- R7: Type 1 is skipped. Words inside its length are never decoded as headers.
- R8: Type 3 latches the word that follows its header into `freq_mhz_o`. A type 3 record with length 0 is a format error (code 2).
- R9: Type 4 sets `mbox_off_o` to the offset of its first value byte (header offset + 4) and sets `mbox_len_o` to its length field.
- R10: `mbox_ok_o` is high exactly when `mbox_len_o` is at least 0x12.
- R11: Any type other than 0 to 4 is skipped when bit 31 is clear. When bit 31 is set it ends the walk with error code 3.
- R12: If the next header offset would exceed 8188, the walk ends with error code 4 (overrun). A header placed exactly at 8188 is still read.
- R13: A start that arrives while the walker is busy is ignored. After a walk ends, the outputs hold until the next start. A new start restores the default values.
- R14: The checks on one header apply in this order: type 0, length format, terminator, required-unknown, short type 3, overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| rd_en_o | output | 1 | Read request to the configuration space |
| rd_addr_o | output | 11 | Word address of the read |
| rd_data_i | input | 32 | Read data, valid the cycle after `rd_en_o` |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished, held until the next start |
| err_o | output | 1 | Walk finished with an error |
| err_code_o | output | 3 | 0 none, 1 type zero, 2 format, 3 required unknown, 4 overrun |
| freq_mhz_o | output | 32 | Latched clock frequency in MHz |
| mbox_off_o | output | 16 | Mailbox byte offset |
| mbox_len_o | output | 16 | Mailbox byte length |
| mbox_ok_o | output | 1 | Mailbox length is at least 0x12 |

## Verification
The bench goes after several boundaries and shows what a wrong design would do at each:
- Empty anchor. A design that treats the zero word at the anchor as a type 0 record would report error 1 instead of finishing cleanly.
- Exact end of the space. A record chain that ends precisely at the last word must finish cleanly, while one word further must overrun. An off-by-one in the limit flips one of these two results.
- Hidden headers. Padding records contain words that look like frequency headers, and a terminator is followed by a frequency record. A walker that mis-steps by the header word, or keeps going past the end marker, latches a wrong frequency.
- Restart. A start is pulsed mid-walk after the anchor word has been corrupted. A walker that restarts on it reports a type-zero error.
- Checking order and random chains. Required and non-required unknown types, odd lengths and a zero-length frequency record probe the order of the checks. Random chains with short records cover the general flow.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;
  localparam logic [14:0] T_ZERO = 15'd0;
  localparam logic [14:0] T_PAD  = 15'd1;
  localparam logic [14:0] T_END  = 15'd2;
  localparam logic [14:0] T_FREQ = 15'd3;
  localparam logic [14:0] T_MBOX = 15'd4;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_TYPE0 = 3'd1,
    ERR_FMT   = 3'd2,
    ERR_REQ   = 3'd3,
    ERR_OVR   = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    ACT_SKIP,
    ACT_END,
    ACT_FREQ,
    ACT_MBOX,
    ACT_FAIL
  } act_e;

  typedef struct packed {
    logic        req;
    logic [14:0] typ;
    logic [15:0] len;
  } hdr_t;
endpackage

// File: rtl/cap_hdr_dec.sv
module cap_hdr_dec
  import cap_walk_pkg::*;
#(
  parameter int SPACE_BYTES = 8192,
  parameter int OFF_W       = $clog2(SPACE_BYTES)
) (
  input  logic [31:0]      word_i,
  input  logic [OFF_W-1:0] cur_i,
  output act_e             act_o,
  output err_e             code_o,
  output logic [OFF_W-1:0] nxt_o,
  output logic [15:0]      len_o
);
  localparam int NXT_W = 18;
  localparam logic [NXT_W-1:0] LIMIT = NXT_W'(SPACE_BYTES - 4);

  hdr_t             hdr;
  logic [NXT_W-1:0] nxt_full;
  logic             known;

  assign hdr      = hdr_t'(word_i);
  assign len_o    = hdr.len;
  assign nxt_full = NXT_W'(cur_i) + NXT_W'(4) + NXT_W'(hdr.len);
  assign nxt_o    = nxt_full[OFF_W-1:0];
  assign known    = (hdr.typ == T_PAD) || (hdr.typ == T_FREQ) || (hdr.typ == T_MBOX);

  // check order is part of the contract
  always_comb begin
    act_o  = ACT_SKIP;
    code_o = ERR_NONE;
    if (hdr.typ == T_ZERO) begin
      act_o  = ACT_FAIL;
      code_o = ERR_TYPE0;
    end else if (hdr.len[1:0] != 2'b00) begin
      act_o  = ACT_FAIL;
      code_o = ERR_FMT;
    end else if (hdr.typ == T_END) begin
      act_o  = ACT_END;
    end else if (!known && hdr.req) begin
      act_o  = ACT_FAIL;
      code_o = ERR_REQ;
    end else if (hdr.typ == T_FREQ && hdr.len == 16'd0) begin
      act_o  = ACT_FAIL;
      code_o = ERR_FMT;
    end else if (nxt_full > LIMIT) begin
      act_o  = ACT_FAIL;
      code_o = ERR_OVR;
    end else if (hdr.typ == T_FREQ) begin
      act_o  = ACT_FREQ;
    end else if (hdr.typ == T_MBOX) begin
      act_o  = ACT_MBOX;
    end
  end
endmodule

// File: rtl/cap_param_regs.sv
module cap_param_regs #(
  parameter int          LEN_W   = 16,
  parameter logic [15:0] DEF_OFF = 16'h1800,
  parameter logic [15:0] DEF_LEN = 16'h01F8,
  parameter logic [15:0] MIN_LEN = 16'h0012
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_def_i,
  input  logic             ld_freq_i,
  input  logic [31:0]      freq_i,
  input  logic             ld_mbox_i,
  input  logic [LEN_W-1:0] mbox_off_i,
  input  logic [LEN_W-1:0] mbox_len_i,
  output logic [31:0]      freq_o,
  output logic [LEN_W-1:0] mbox_off_o,
  output logic [LEN_W-1:0] mbox_len_o,
  output logic             mbox_ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o     <= '0;
      mbox_off_o <= LEN_W'(DEF_OFF);
      mbox_len_o <= LEN_W'(DEF_LEN);
    end else if (ld_def_i) begin
      freq_o     <= '0;
      mbox_off_o <= LEN_W'(DEF_OFF);
      mbox_len_o <= LEN_W'(DEF_LEN);
    end else begin
      if (ld_freq_i) freq_o <= freq_i;
      if (ld_mbox_i) begin
        mbox_off_o <= mbox_off_i;
        mbox_len_o <= mbox_len_i;
      end
    end
  end

  assign mbox_ok_o = (mbox_len_o >= LEN_W'(MIN_LEN));
endmodule

// File: rtl/cap_walk_seq.sv
module cap_walk_seq
  import cap_walk_pkg::*;
#(
  parameter int SPACE_BYTES = 8192,
  parameter int ANCHOR      = 'h58,
  parameter int OFF_W       = $clog2(SPACE_BYTES),
  parameter int AW          = OFF_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [31:0]      rd_data_i,
  input  act_e             act_i,
  input  err_e             code_i,
  input  logic [OFF_W-1:0] nxt_i,
  output logic [OFF_W-1:0] cur_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic             ld_def_o,
  output logic             ld_freq_o,
  output logic             ld_mbox_o
);
  typedef enum logic [2:0] {S_IDLE, S_HREQ, S_HDAT, S_VREQ, S_VDAT} st_e;

  st_e              st_q;
  logic [OFF_W-1:0] cur_q, nxt_q, val_off;
  logic             first_q, empty;

  assign cur_o     = cur_q;
  assign val_off   = cur_q + OFF_W'(4);
  assign busy_o    = (st_q != S_IDLE);
  assign rd_en_o   = (st_q == S_HREQ) || (st_q == S_VREQ);
  assign rd_addr_o = (st_q == S_VREQ) ? val_off[OFF_W-1:2] : cur_q[OFF_W-1:2];
  assign empty     = first_q && (rd_data_i == 32'd0);
  assign ld_def_o  = (st_q == S_IDLE) && start_i;
  assign ld_freq_o = (st_q == S_VDAT);
  assign ld_mbox_o = (st_q == S_HDAT) && !empty && (act_i == ACT_MBOX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cur_q      <= '0;
      nxt_q      <= '0;
      first_q    <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q       <= S_HREQ;
          cur_q      <= OFF_W'(ANCHOR);
          first_q    <= 1'b1;
          done_o     <= 1'b0;
          err_o      <= 1'b0;
          err_code_o <= ERR_NONE;
        end
        S_HREQ: st_q <= S_HDAT;
        S_HDAT: begin
          first_q <= 1'b0;
          if (empty || act_i == ACT_END) begin
            st_q   <= S_IDLE;
            done_o <= 1'b1;
          end else if (act_i == ACT_FAIL) begin
            st_q       <= S_IDLE;
            done_o     <= 1'b1;
            err_o      <= 1'b1;
            err_code_o <= code_i;
          end else if (act_i == ACT_FREQ) begin
            st_q  <= S_VREQ;
            nxt_q <= nxt_i;
          end else begin
            st_q  <= S_HREQ;
            cur_q <= nxt_i;
          end
        end
        S_VREQ: st_q <= S_VDAT;
        S_VDAT: begin
          st_q  <= S_HREQ;
          cur_q <= nxt_q;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cap_list_walker.sv
module cap_list_walker
  import cap_walk_pkg::*;
#(
  parameter int          SPACE_BYTES = 8192,
  parameter int          ANCHOR      = 'h58,
  parameter int          LEN_W       = 16,
  parameter logic [15:0] DEF_OFF     = 16'h1800,
  parameter logic [15:0] DEF_LEN     = 16'h01F8,
  parameter logic [15:0] MIN_LEN     = 16'h0012,
  parameter int          AW          = $clog2(SPACE_BYTES) - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             rd_en_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [31:0]      rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic [31:0]      freq_mhz_o,
  output logic [LEN_W-1:0] mbox_off_o,
  output logic [LEN_W-1:0] mbox_len_o,
  output logic             mbox_ok_o
);
  localparam int OFF_W = $clog2(SPACE_BYTES);

  act_e             act;
  err_e             code;
  logic [OFF_W-1:0] nxt, cur;
  logic [15:0]      len;
  logic             ld_def, ld_freq, ld_mbox;
  logic [OFF_W:0]   val_pos;

  assign val_pos = {1'b0, cur} + (OFF_W+1)'(4);

  cap_hdr_dec #(.SPACE_BYTES(SPACE_BYTES), .OFF_W(OFF_W)) u_dec (
    .word_i(rd_data_i), .cur_i(cur), .act_o(act), .code_o(code),
    .nxt_o(nxt), .len_o(len)
  );

  cap_walk_seq #(.SPACE_BYTES(SPACE_BYTES), .ANCHOR(ANCHOR), .OFF_W(OFF_W), .AW(AW)) u_seq (
    .clk_i, .rst_ni, .start_i, .rd_en_o, .rd_addr_o, .rd_data_i,
    .act_i(act), .code_i(code), .nxt_i(nxt), .cur_o(cur),
    .busy_o, .done_o, .err_o, .err_code_o,
    .ld_def_o(ld_def), .ld_freq_o(ld_freq), .ld_mbox_o(ld_mbox)
  );

  cap_param_regs #(.LEN_W(LEN_W), .DEF_OFF(DEF_OFF), .DEF_LEN(DEF_LEN), .MIN_LEN(MIN_LEN)) u_regs (
    .clk_i, .rst_ni, .ld_def_i(ld_def), .ld_freq_i(ld_freq), .freq_i(rd_data_i),
    .ld_mbox_i(ld_mbox), .mbox_off_i(LEN_W'(val_pos)), .mbox_len_i(LEN_W'(len)),
    .freq_o(freq_mhz_o), .mbox_off_o, .mbox_len_o, .mbox_ok_o
  );
endmodule

// File: rtl/cap_list_walker_chk.sv
module cap_list_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        rd_en_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] freq_mhz_o
);
  // R13
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !done_o));

  // R13
  busy_not_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  // R4
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R3
  read_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);

  // R13
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(freq_mhz_o) && $stable(done_o) && $stable(err_o)));
endmodule

bind cap_list_walker cap_list_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_en_o(rd_en_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .freq_mhz_o(freq_mhz_o)
);

// File: tb/cap_list_walker_bench.sv
`timescale 1ns/1ps
module cap_list_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_en;
  logic [10:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        busy, done, err, mbox_ok;
  logic [2:0]  code;
  logic [31:0] freq;
  logic [15:0] mbox_off, mbox_len;

  logic [31:0] mem [2048];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  cap_list_walker u_cap_list_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code),
    .freq_mhz_o(freq), .mbox_off_o(mbox_off), .mbox_len_o(mbox_len), .mbox_ok_o(mbox_ok)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(bit req, int typ, int len);
    return {req, 15'(typ), 16'(len)};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
  endtask

  task automatic put(int off, logic [31:0] w);
    mem[off >> 2] = w;
  endtask

  // reference walk from the requirements
  logic [2:0]  e_code;
  logic [31:0] e_freq;
  logic [15:0] e_off, e_len;

  task automatic ref_walk();
    int off;
    logic [31:0] w;
    int t, l, nxt;
    bit r, known;
    off = 'h58; e_code = 0; e_freq = 0; e_off = 16'h1800; e_len = 16'h01F8;
    if (mem[off >> 2] == 0) return;
    for (int k = 0; k < 4000; k++) begin
      w = mem[off >> 2]; r = w[31]; t = int'(w[30:16]); l = int'(w[15:0]);
      if (t == 0) begin e_code = 1; return; end
      if (l % 4 != 0) begin e_code = 2; return; end
      if (t == 2) return;
      known = (t == 1 || t == 3 || t == 4);
      if (!known && r) begin e_code = 3; return; end
      if (t == 3 && l == 0) begin e_code = 2; return; end
      nxt = off + 4 + l;
      if (nxt > 8188) begin e_code = 4; return; end
      if (t == 3) e_freq = mem[(off + 4) >> 2];
      if (t == 4) begin e_off = 16'(off + 4); e_len = 16'(l); end
      off = nxt;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk({tag, " R2 done"}, 32'(done), 32'd1);
  endtask

  task automatic compare(string tag);
    chk({tag, " err"}, 32'(err), 32'(e_code != 0));
    chk({tag, " code"}, 32'(code), 32'(e_code));
    chk({tag, " R8 freq"}, freq, e_freq);
    chk({tag, " R9 off"}, 32'(mbox_off), 32'(e_off));
    chk({tag, " R9 len"}, 32'(mbox_len), 32'(e_len));
    chk({tag, " R10 ok"}, 32'(mbox_ok), 32'(e_len >= 16'h12));
  endtask

  task automatic run(string tag);
    ref_walk();
    pulse_start();
    wait_done(tag);
    compare(tag);
  endtask

  initial begin
    int off, n, kind, len;
    void'($urandom(32'h5eed_1234));
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 rd_en", 32'(rd_en), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 freq", freq, 0);
    chk("R1 off", 32'(mbox_off), 32'h1800);
    chk("R1 len", 32'(mbox_len), 32'h1F8);
    chk("R1 ok", 32'(mbox_ok), 1);

    // R2 empty list, also check the first read address
    clear_mem();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 first addr", 32'(rd_addr), 32'h16);
    chk("R2 first rd_en", 32'(rd_en), 1);
    ref_walk(); wait_done("R2 empty"); compare("R2 empty");

    // R5 end marker stops; a freq record after it is not used
    clear_mem();
    put('h58, hdr(0, 3, 4)); put('h5C, 32'd800);
    put('h60, hdr(0, 2, 0)); put('h64, hdr(0, 3, 4)); put('h68, 32'd999);
    run("R5 end");
    chk("R5 freq kept", freq, 32'd800);

    // R7 padding holding fake headers; R9/R10 large mailbox
    clear_mem();
    put('h58, hdr(0, 1, 8)); put('h5C, hdr(0, 3, 4)); put('h60, 32'd77);
    put('h64, hdr(0, 4, 32)); put('h88, hdr(0, 2, 0));
    run("R7 pad");
    chk("R7 freq untouched", freq, 0);
    chk("R9 mbox off", 32'(mbox_off), 32'h68);

    // R10 short mailbox
    clear_mem();
    put('h58, hdr(0, 4, 16)); put('h6C, hdr(0, 2, 0));
    run("R10 short");
    chk("R10 not ok", 32'(mbox_ok), 0);

    // R13 new start restores defaults
    clear_mem();
    run("R13 defaults");
    chk("R13 len default", 32'(mbox_len), 32'h1F8);

    // R4 bad length
    clear_mem(); put('h58, hdr(0, 1, 6));
    run("R4 fmt");
    chk("R4 code", 32'(code), 2);

    // R6 type zero with required flag, R14 beats bad length
    clear_mem(); put('h58, hdr(1, 0, 3));
    run("R6 type0");
    chk("R6 R14 code", 32'(code), 1);

    // R8 zero-length freq
    clear_mem(); put('h58, hdr(0, 3, 0));
    run("R8 short");
    chk("R8 code", 32'(code), 2);

    // R11 unknown skipped, then required unknown fails
    clear_mem();
    put('h58, hdr(0, 9, 4)); put('h60, hdr(0, 3, 4)); put('h64, 32'd1200);
    put('h68, hdr(1, 7, 0));
    run("R11 unk");
    chk("R11 code", 32'(code), 3);
    chk("R11 freq", freq, 32'd1200);

    // R12 exact fit at last word vs one word over
    clear_mem(); put('h58, hdr(0, 1, 8096)); put(8188, hdr(0, 2, 0));
    run("R12 fit");
    chk("R12 fit err", 32'(err), 0);
    clear_mem(); put('h58, hdr(0, 1, 8100));
    run("R12 over");
    chk("R12 code", 32'(code), 4);
    // R12 no terminator anywhere
    clear_mem();
    for (int a = 'h58; a < 8192; a += 4) put(a, hdr(0, 1, 0));
    run("R12 chain");
    chk("R12 chain code", 32'(code), 4);

    // R13 start while busy is ignored
    clear_mem();
    for (int i = 0; i < 40; i++) put('h58 + 4 * i, hdr(0, 1, 0));
    put('h58 + 160, hdr(0, 3, 4)); put('h58 + 164, 32'd555);
    put('h58 + 168, hdr(0, 2, 0));
    ref_walk();
    pulse_start();
    repeat (10) @(negedge clk);
    put('h58, hdr(0, 0, 4));
    pulse_start();
    wait_done("R13 busy");
    compare("R13 busy");
    repeat (20) @(negedge clk);
    chk("R13 hold done", 32'(done), 1);
    chk("R13 hold freq", freq, 32'd555);

    // random chains (R3)
    for (int it = 0; it < 40; it++) begin
      clear_mem();
      off = 'h58;
      n = $urandom_range(1, 6);
      for (int j = 0; j < n; j++) begin
        kind = $urandom_range(0, 9);
        len = $urandom_range(0, 5) * 4;
        if ($urandom_range(0, 9) == 0) len = len + $urandom_range(1, 3);
        case (kind)
          0, 1, 2: put(off, hdr(0, 1, len));
          3, 4:    put(off, hdr(0, 3, len));
          5, 6:    put(off, hdr(0, 4, len));
          7:       put(off, hdr($urandom_range(0, 1), $urandom_range(5, 300), len));
          8:       put(off, hdr($urandom_range(0, 1), 0, len));
          default: put(off, hdr(0, 4, 4 * $urandom_range(4, 8)));
        endcase
        len = int'(mem[off >> 2][15:0]) & ~3;
        for (int v = 0; v < len / 4; v++) put(off + 4 + 4 * v, $urandom | 32'h1);
        off = off + 4 + len;
      end
      put(off, hdr(0, 2, 0));
      run("R3 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule